// File: doc/BRIEF.md
# Prefixed Operand Address Generator

This block works out where an instruction's operand lives for a small 64-bit accumulator processor whose instructions vary in length. On a `start` pulse it takes the program counter (already pointing past the opcode), the raw byte that may be a prefix, an addressing-mode class, and the two index registers. It then reads whatever address or pointer bytes it needs from memory, one byte per cycle, through a read port with one cycle of latency. When it finishes, it presents the effective address and the advanced program counter, and pulses `done`.

A prefix byte can stretch the length of an embedded address or of an immediate operand. The same two-bit length field maps to different byte counts in the long-address family and in the short-address family. Indirect classes then fetch an eight-byte little-endian pointer. An index register can be added before that fetch, or after it.

Top module: `opaddr_gen`

## Requirements
- R1: After a synchronous reset, `done`, `busy` and `mem_rd` are 0, and `ea` and `pc_out` are 0.
- R2: The prefix byte takes effect only when its bits [1:0] are both 1. Any other value behaves exactly like a prefix of 0x00.
- R3: Long-address class (mode 4): prefix bits [3:2] give the address length. Code 0 means 2 bytes, 1 means 5, 2 means 7 and 3 means 8. The bytes are read from `pc_in` upward with the lowest address as the least significant byte. `ea` is the assembled value and `pc_out` is `pc_in` plus the length.
- R4: Short-address class (mode 5): prefix bits [3:2] give the length. Code 0 means 1 byte, 1 means 3, 2 means 6 and 3 means 4. The bytes are assembled the same way, and `pc_out` is `pc_in` plus the length.
- R5: Short-address classes with an index (mode 6 adds X, mode 7 adds Y) add the index to the fetched address, modulo 2^64.
- R6: Pointer class (mode 8) fetches the short address as in R4. It then reads 8 bytes, little-endian, starting at that address, and the result is `ea`.
- R7: Mode 9 adds X to the fetched short address before the pointer read. Mode 10 adds Y to the pointer after it is read.
- R8: Immediate class (mode 1): `ea` equals `pc_in`, and `pc_out` is `pc_in + (1 << prefix[7:4])` under the R2 qualification. No memory read takes place.
- R9: Mode 2 gives `ea = pc_in` and `pc_out = pc_in + 1`. Mode 3 gives `ea = pc_in` and `pc_out = pc_in`. No memory read takes place in either mode.
- R10: Mode 0 (and the unused codes 11 to 15) sets `done` on the cycle after `start`, with `ea = 0` and `pc_out = pc_in`.
- R11: `done` is a single-cycle pulse. At most one byte read is issued per cycle, and only while `busy`. The number of reads equals the address length plus 8 for the pointer classes. A `start` that arrives while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (sampled when idle) |
| mode | input | 4 | Addressing-mode class code |
| prefix | input | 8 | Candidate prefix byte |
| pc_in | input | DW | Program counter after the opcode |
| idx_x | input | DW | X index register |
| idx_y | input | DW | Y index register |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | DW | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | DW | Effective address |
| pc_out | output | DW | Advanced program counter |

## Verification
The properties assume that memory returns the byte for a request on the cycle after `mem_rd`, and that `start` is a clean synchronous pulse whose inputs are meaningful only while the block is idle. The stimulus drives every input at the falling edge from a registered byte memory that behaves exactly this way. It holds `start` for a single cycle, except in one deliberate test where a second pulse arrives during a busy computation. The bench model computes expected addresses from its own copy of the memory contents, using the length tables stated in the requirements.

// File: rtl/oag_pkg.sv
package oag_pkg;

  typedef enum logic [3:0] {
    AM_NONE      = 4'd0,
    AM_IMM       = 4'd1,
    AM_IMM_STEP1 = 4'd2,
    AM_IMM_HOLD  = 4'd3,
    AM_ABS       = 4'd4,
    AM_SHORT     = 4'd5,
    AM_SHORT_X   = 4'd6,
    AM_SHORT_Y   = 4'd7,
    AM_PTR       = 4'd8,
    AM_PTR_X     = 4'd9,
    AM_PTR_Y     = 4'd10
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_PTR  = 2'd2
  } phase_e;

  // byte length of the pointer read by the indirect classes
  localparam int PTR_BYTES = 8;

  function automatic logic is_ptr_mode(input amode_e m);
    return (m == AM_PTR) || (m == AM_PTR_X) || (m == AM_PTR_Y);
  endfunction

  function automatic logic is_short_mode(input amode_e m);
    return (m == AM_SHORT) || (m == AM_SHORT_X) || (m == AM_SHORT_Y) || is_ptr_mode(m);
  endfunction

endpackage

// File: rtl/oag_len_decode.sv
// Qualifies the candidate prefix byte and turns its fields into byte counts.
module oag_len_decode #(
  parameter int DW    = 64,
  parameter int CNT_W = 4
) (
  input  logic [7:0]       prefix,
  output logic [CNT_W-1:0] long_len,
  output logic [CNT_W-1:0] short_len,
  output logic [DW-1:0]    imm_step
);
  logic       qual;
  logic [1:0] code;
  logic [3:0] size_sh;

  assign qual    = &prefix[1:0];
  assign code    = qual ? prefix[3:2] : 2'd0;
  assign size_sh = qual ? prefix[7:4] : 4'd0;

  always_comb begin
    unique case (code)
      2'd0: long_len = CNT_W'(2);
      2'd1: long_len = CNT_W'(5);
      2'd2: long_len = CNT_W'(7);
      default: long_len = CNT_W'(8);
    endcase
  end

  always_comb begin
    unique case (code)
      2'd0: short_len = CNT_W'(1);
      2'd1: short_len = CNT_W'(3);
      2'd2: short_len = CNT_W'(6);
      default: short_len = CNT_W'(4);
    endcase
  end

  assign imm_step = DW'(1) << size_sh;

endmodule

// File: rtl/oag_byte_gather.sv
// Little-endian byte assembler: one lane written per cycle.
module oag_byte_gather #(
  parameter int NB    = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_byte,
  output logic [NB*8-1:0]   acc_next
);
  logic [NB*8-1:0] acc_q;

  for (genvar j = 0; j < NB; j++) begin : g_lane
    assign acc_next[j*8 +: 8] = (wr_en && (wr_idx == IDX_W'(j))) ? wr_byte : acc_q[j*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else            acc_q <= acc_next;
  end

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [7:0]    prefix,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  output logic          mem_rd,
  output logic [DW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] pc_out
);
  import oag_pkg::*;

  localparam int NB    = DW / 8;
  localparam int CNT_W = $clog2(NB + 1);
  localparam int IDX_W = $clog2(NB);

  phase_e          st;
  amode_e          mode_q;
  amode_e          mode_in;
  logic [DW-1:0]   base_q, pc_q, pc_fin_q, x_q, y_q;
  logic [CNT_W-1:0] n_q, iss_q;
  logic            pend_q;
  logic [IDX_W-1:0] idx_q;

  logic [CNT_W-1:0] long_len, short_len;
  logic [DW-1:0]    imm_step;
  logic [DW-1:0]    acc_next;
  logic             rd_issue, last_byte, gather_clr;
  logic [DW-1:0]    pre_off, post_off, addr_sum;

  assign mode_in = amode_e'(mode);

  oag_len_decode #(.DW(DW), .CNT_W(CNT_W)) u_len (
    .prefix    (prefix),
    .long_len  (long_len),
    .short_len (short_len),
    .imm_step  (imm_step)
  );

  oag_byte_gather #(.NB(NB), .IDX_W(IDX_W)) u_gather (
    .clk      (clk),
    .rst      (rst),
    .clr      (gather_clr),
    .wr_en    (pend_q),
    .wr_idx   (idx_q),
    .wr_byte  (mem_rdata),
    .acc_next (acc_next)
  );

  assign rd_issue   = (st != ST_IDLE) && (iss_q < n_q);
  assign last_byte  = pend_q && (CNT_W'(idx_q) == (n_q - CNT_W'(1)));
  assign gather_clr = ((st == ST_IDLE) && start) || ((st == ST_ADDR) && last_byte);

  assign mem_rd   = rd_issue;
  assign mem_addr = base_q + DW'(iss_q);
  assign busy     = (st != ST_IDLE);

  // index applied to the fetched address, and index applied to the pointer
  assign pre_off  = ((mode_q == AM_SHORT_X) || (mode_q == AM_PTR_X)) ? x_q :
                    (mode_q == AM_SHORT_Y) ? y_q : '0;
  assign post_off = (mode_q == AM_PTR_Y) ? y_q : '0;
  assign addr_sum = acc_next + pre_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mode_q   <= AM_NONE;
      base_q   <= '0;
      pc_q     <= '0;
      pc_fin_q <= '0;
      x_q      <= '0;
      y_q      <= '0;
      n_q      <= '0;
      iss_q    <= '0;
      pend_q   <= 1'b0;
      idx_q    <= '0;
      ea       <= '0;
      pc_out   <= '0;
      done     <= 1'b0;
    end else begin
      done   <= 1'b0;
      pend_q <= rd_issue;
      idx_q  <= iss_q[IDX_W-1:0];
      if (rd_issue) iss_q <= iss_q + CNT_W'(1);

      unique case (st)
        ST_IDLE: begin
          if (start) begin
            mode_q <= mode_in;
            base_q <= pc_in;
            pc_q   <= pc_in;
            x_q    <= idx_x;
            y_q    <= idx_y;
            iss_q  <= '0;
            unique case (mode_in)
              AM_IMM: begin
                ea <= pc_in; pc_out <= pc_in + imm_step; done <= 1'b1;
              end
              AM_IMM_STEP1: begin
                ea <= pc_in; pc_out <= pc_in + DW'(1); done <= 1'b1;
              end
              AM_IMM_HOLD: begin
                ea <= pc_in; pc_out <= pc_in; done <= 1'b1;
              end
              AM_ABS: begin
                n_q <= long_len; st <= ST_ADDR;
              end
              AM_SHORT, AM_SHORT_X, AM_SHORT_Y, AM_PTR, AM_PTR_X, AM_PTR_Y: begin
                n_q <= short_len; st <= ST_ADDR;
              end
              default: begin
                ea <= '0; pc_out <= pc_in; done <= 1'b1;
              end
            endcase
          end
        end
        ST_ADDR: begin
          if (last_byte) begin
            if (is_ptr_mode(mode_q)) begin
              st       <= ST_PTR;
              base_q   <= addr_sum;
              pc_fin_q <= pc_q + DW'(n_q);
              n_q      <= CNT_W'(PTR_BYTES);
              iss_q    <= '0;
            end else begin
              st     <= ST_IDLE;
              ea     <= addr_sum;
              pc_out <= pc_q + DW'(n_q);
              done   <= 1'b1;
            end
          end
        end
        ST_PTR: begin
          if (last_byte) begin
            st     <= ST_IDLE;
            ea     <= acc_next + post_off;
            pc_out <= pc_fin_q;
            done   <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/oag_checker.sv
module oag_checker #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [3:0]    mode,
  input logic [DW-1:0] pc_in,
  input logic          mem_rd,
  input logic [DW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] ea,
  input logic [DW-1:0] pc_out
);
  // R11: reads only while a computation is in flight
  p_rd_in_busy_r11: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: no read is outstanding when the result is presented
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_rd && !busy);

  // R3: back-to-back reads walk upward one byte at a time
  p_addr_walk_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + DW'(1)));

  // R8: immediate class returns the current program counter next cycle
  p_imm_ea_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 4'd1) |=> (done && ea == $past(pc_in)));

  // R9: hold variant leaves the program counter in place
  p_hold_pc_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 4'd3) |=> (done && pc_out == $past(pc_in)));

  // R10: implied class finishes in one cycle with a zero address
  p_none_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == 4'd0) |=> (done && ea == '0 && pc_out == $past(pc_in)));
endmodule

bind opaddr_gen oag_checker #(.DW(DW)) u_oag_checker (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .mode     (mode),
  .pc_in    (pc_in),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .busy     (busy),
  .done     (done),
  .ea       (ea),
  .pc_out   (pc_out)
);

// File: tb/test_opaddr_gen.sv
module test_opaddr_gen;
  localparam int DW = 64;
  localparam int MEMSZ = 1024;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [7:0]    prefix = '0;
  logic [DW-1:0] pc_in = '0, idx_x = '0, idx_y = '0;
  logic          mem_rd, busy, done;
  logic [DW-1:0] mem_addr, ea, pc_out;
  logic [7:0]    mem_rdata;
  logic [7:0]    mem [MEMSZ];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  opaddr_gen #(.DW(DW)) i_opaddr_gen (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .prefix(prefix),
    .pc_in(pc_in), .idx_x(idx_x), .idx_y(idx_y), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .ea(ea), .pc_out(pc_out)
  );

  // registered byte memory, one cycle of read latency
  always_ff @(posedge clk) mem_rdata <= mem[mem_addr[9:0]];

  // vector: mode[203:200] prefix[199:192] pc[191:128] x[127:64] y[63:0]
  localparam logic [203:0] VEC [NV] = '{
    {4'd0,  8'h00, 64'h40,  64'h0,  64'h0},                  // R10
    {4'd1,  8'h33, 64'h100, 64'h0,  64'h0},                  // R8 +8
    {4'd1,  8'h30, 64'h100, 64'h0,  64'h0},                  // R2 unqualified -> +1
    {4'd2,  8'h33, 64'h80,  64'h0,  64'h0},                  // R9
    {4'd3,  8'h33, 64'h80,  64'h0,  64'h0},                  // R9
    {4'd4,  8'h00, 64'h10,  64'h0,  64'h0},                  // R3 2 bytes
    {4'd4,  8'h07, 64'h21,  64'h0,  64'h0},                  // R3 5 bytes
    {4'd4,  8'h0B, 64'h37,  64'h0,  64'h0},                  // R3 7 bytes
    {4'd4,  8'h0F, 64'h50,  64'h0,  64'h0},                  // R3 8 bytes
    {4'd4,  8'h0C, 64'h60,  64'h0,  64'h0},                  // R2 -> 2 bytes
    {4'd5,  8'h03, 64'h70,  64'h0,  64'h0},                  // R4 1 byte
    {4'd5,  8'h07, 64'h90,  64'h0,  64'h0},                  // R4 3 bytes
    {4'd5,  8'h0B, 64'hA3,  64'h0,  64'h0},                  // R4 6 bytes
    {4'd5,  8'h0F, 64'hC1,  64'h0,  64'h0},                  // R4 4 bytes
    {4'd6,  8'h03, 64'hD0,  64'h5,  64'h0},                  // R5 X
    {4'd7,  8'h07, 64'hE0,  64'h0,  64'hFFFF_FFFF_FFFF_FFFF}, // R5 Y wraps
    {4'd8,  8'h03, 64'h200, 64'h0,  64'h0},                  // R6
    {4'd9,  8'h03, 64'h210, 64'h20, 64'h0},                  // R7 X before
    {4'd10, 8'h07, 64'h220, 64'h0,  64'h1000}                // R7 Y after
  };

  function automatic logic [DW-1:0] gather(input logic [DW-1:0] a, input int n);
    logic [DW-1:0] v = '0;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] ai = a + DW'(i);
      v[i*8 +: 8] = mem[ai[9:0]];
    end
    return v;
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd1: return "R8";
      4'd2, 4'd3: return "R9";
      4'd4: return "R3";
      4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9, 4'd10: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [203:0] v);
    logic [3:0]    m  = v[203:200];
    logic [7:0]    p  = v[199:192];
    logic [DW-1:0] pc = v[191:128];
    logic [DW-1:0] x  = v[127:64];
    logic [DW-1:0] y  = v[63:0];
    logic          q  = &p[1:0];
    logic [1:0]    c  = q ? p[3:2] : 2'd0;
    logic [3:0]    s  = q ? p[7:4] : 4'd0;
    logic [DW-1:0] e_ea, e_pc, a;
    int n, e_rd, rd, wait_cnt;
    int long_t [4]  = '{2, 5, 7, 8};
    int short_t [4] = '{1, 3, 6, 4};
    e_rd = 0;
    case (m)
      4'd1: begin e_ea = pc; e_pc = pc + (DW'(1) << s); end
      4'd2: begin e_ea = pc; e_pc = pc + 1; end
      4'd3: begin e_ea = pc; e_pc = pc; end
      4'd4: begin n = long_t[c]; e_ea = gather(pc, n); e_pc = pc + DW'(n); e_rd = n; end
      4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: begin
        n = short_t[c];
        a = gather(pc, n);
        if (m == 4'd6 || m == 4'd9) a = a + x;
        if (m == 4'd7) a = a + y;
        e_rd = n;
        if (m >= 4'd8) begin
          a = gather(a, 8);
          e_rd = n + 8;
          if (m == 4'd10) a = a + y;
        end
        e_ea = a; e_pc = pc + DW'(n);
      end
      default: begin e_ea = '0; e_pc = pc; end
    endcase
    @(negedge clk);
    start = 1'b1; mode = m; prefix = p; pc_in = pc; idx_x = x; idx_y = y;
    @(negedge clk);
    start = 1'b0;
    rd = 0; wait_cnt = 0;
    while (!done && wait_cnt < 200) begin
      if (mem_rd) rd++;
      @(negedge clk);
      wait_cnt++;
    end
    check(req_of(m), "ea", ea, e_ea);
    check(req_of(m), "pc_out", pc_out, e_pc);
    check("R11", "read count", DW'(rd), DW'(e_rd));
    @(negedge clk);
    check("R11", "done pulse width", DW'(done), DW'(0));
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'((i * 73 + 19) ^ (i >> 3));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "done", DW'(done), DW'(0));
    check("R1", "busy", DW'(busy), DW'(0));
    check("R1", "mem_rd", DW'(mem_rd), DW'(0));
    check("R1", "ea", ea, '0);
    check("R1", "pc_out", pc_out, '0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_op(VEC[k]);

    // R11: a second start during a busy computation is ignored
    begin
      int rd = 0;
      int wc = 0;
      @(negedge clk);
      start = 1'b1; mode = 4'd4; prefix = 8'h0F; pc_in = 64'h300; idx_x = '0; idx_y = '0;
      @(negedge clk);
      start = 1'b0;
      if (mem_rd) rd++;
      @(negedge clk);
      if (mem_rd) rd++;
      start = 1'b1; mode = 4'd0; pc_in = 64'h999;
      @(negedge clk);
      start = 1'b0;
      while (!done && wc < 200) begin
        if (mem_rd) rd++;
        @(negedge clk);
        wc++;
      end
      check("R11", "busy start ea", ea, gather(64'h300, 8));
      check("R11", "busy start pc_out", pc_out, 64'h308);
      check("R11", "busy start reads", DW'(rd), DW'(8));
    end

    // R1: reset in the middle of a computation returns to idle
    @(negedge clk);
    start = 1'b1; mode = 4'd8; prefix = 8'h03; pc_in = 64'h240;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", DW'(busy), DW'(0));
    check("R1", "mem_rd after reset", DW'(mem_rd), DW'(0));
    check("R1", "ea after reset", ea, '0);
    rst = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule